// File: doc/BRIEF.md
# Charging Port Load-Detect Status Generator

This block watches a charging port's output current through a set of comparator flags and drives three outputs: an active-low load-present status line, a select for a reduced 55 mA low-power current limit, and a request to discharge the port output. It works in two ways, chosen by a four-bit command `{ctl1, ctl2, ctl3, sel}`. In load-detect mode (commands `0111` and `1111`) status drops low once a heavy load has persisted, and rises again once the load has stayed light for a longer time. This lets a system give high charging power to only some of its ports. In power-wake mode (command `0011`), a port that has stayed lightly loaded for a long time moves to the 55 mA limit, so a low-power regulator can feed it. When a device then hits that limit, the block asks for a discharge of fixed length and then restores the high limit. Every other command turns load detection off.

All qualification times are counted in pulses of a millisecond tick input. The count for each window is a parameter, so it can be shortened for simulation. Any break in a qualifying condition restarts that window from zero. The behaviour is one state machine. Its states are `ST_IDLE` (detection off), `ST_WATCH` (light load, status high), `ST_LOADED` (heavy load, status low), `ST_PW_HIGH` (power-wake, high limit, status low), `ST_PW_LOW` (power-wake, 55 mA limit, status high) and `ST_PW_DISCH` (discharge requested, status low). Its transitions are:
- arm: `ST_IDLE` to `ST_WATCH` or `ST_PW_HIGH`, on a command that enables detection.
- load: `ST_WATCH` to `ST_LOADED`, when the heavy-load window fills or a primary detection is seen under `1111`.
- release: `ST_LOADED` to `ST_WATCH`, when the light-load window fills.
- doze: `ST_PW_HIGH` to `ST_PW_LOW`, when the idle window fills.
- wake: `ST_PW_LOW` to `ST_PW_DISCH`, when the current-limit-hit flag is raised.
- restore: `ST_PW_DISCH` to `ST_PW_HIGH`, when the discharge window fills.
- reclass: from any state to the entry state of a new command class, whenever the command class changes.

Top module: `ldet_status_gen`

## Requirements
- R1: After reset `status_n` is 1, `lim_low_pwr` is 0 and `dischg_req` is 0.
- R2: With any command other than `0011`, `0111` or `1111`, one clock after the command is applied `status_n` is 1, `lim_low_pwr` is 0 and `dischg_req` is 0. In this state all current flags, the primary-detect flag and the limit-hit flag are ignored.
- R3: Under `0111` or `1111`, `status_n` goes low once `load_hi` has been seen high on ASSERT_TICKS consecutive ticks. It stays high until then.
- R4: When a qualifying flag drops during a window, that window restarts from zero. A heavy load lasting ASSERT_TICKS-1 ticks, a one-tick gap and another ASSERT_TICKS-1 ticks does not assert status.
- R5: Under `1111`, `prim_det` high drives `status_n` low on the next clock. Under `0111`, `prim_det` has no effect.
- R6: With status low under a load-detect command, `status_n` returns high once `load_lo` has been high on RELEASE_TICKS consecutive ticks.
- R7: On entering `0011` the outputs are `status_n`=0 and `lim_low_pwr`=0. After `pw_idle` has been high on IDLE_TICKS consecutive ticks, `lim_low_pwr` becomes 1 and `status_n` becomes 1.
- R8: In the low-power state, `ilim_hit` drives `status_n` low and `dischg_req` high on the next clock. `dischg_req` stays high for DISCH_TICKS ticks. It then falls, with `lim_low_pwr` at 0 and `status_n` still low.
- R9: Moving between `1110` and `1111` never raises `dischg_req`. Under `1110` status is high.
- R10: `dischg_req` is raised only while the command is `0011`. Leaving `0011` during a discharge withdraws the request on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Mode command `{ctl1, ctl2, ctl3, sel}` |
| tick | input | 1 | One-clock pulse every millisecond |
| load_hi | input | 1 | Load current above low limit + 60 mA |
| load_lo | input | 1 | Load current below low limit + 10 mA |
| pw_idle | input | 1 | Load current below 45 mA |
| ilim_hit | input | 1 | Port is at its active current limit |
| prim_det | input | 1 | BC1.2 primary detection seen on the data lines |
| status_n | output | 1 | Load-present status, active low |
| lim_low_pwr | output | 1 | 1 selects the 55 mA low-power current limit |
| dischg_req | output | 1 | Request to discharge the port output |

## Verification
The assertions take for granted that the inputs are clean, synchronous levels that change only between clock edges. They also assume that `tick` is a single-cycle pulse, and that `cmd` is a settled code rather than a bit-by-bit transition. The stimulus changes every input on the falling clock edge and drives `tick` high for one cycle followed by three low cycles. Each scenario begins by sending an inactive command, so the state machine always starts from the detection-off state.

// File: rtl/ldet_pkg.sv
package ldet_pkg;

    typedef enum logic [1:0] {
        MC_OFF  = 2'd0,
        MC_LOAD = 2'd1,
        MC_PW   = 2'd2
    } mode_cls_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WATCH    = 3'd1,
        ST_LOADED   = 3'd2,
        ST_PW_HIGH  = 3'd3,
        ST_PW_LOW   = 3'd4,
        ST_PW_DISCH = 3'd5
    } ldet_state_t;

    localparam logic [3:0] CMD_PW      = 4'b0011;
    localparam logic [3:0] CMD_DCP_LD  = 4'b0111;
    localparam logic [3:0] CMD_CDP     = 4'b1111;

    localparam int NUM_WIN = 4;
    localparam int WIN_ARM = 0;
    localparam int WIN_REL = 1;
    localparam int WIN_IDL = 2;
    localparam int WIN_DIS = 3;

    function automatic mode_cls_t cmd_class(input logic [3:0] c);
        if (c == CMD_PW)
            return MC_PW;
        else if (c == CMD_DCP_LD || c == CMD_CDP)
            return MC_LOAD;
        else
            return MC_OFF;
    endfunction

    function automatic ldet_state_t entry_state(input mode_cls_t m);
        unique case (m)
            MC_LOAD: return ST_WATCH;
            MC_PW:   return ST_PW_HIGH;
            default: return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ldet_mode_decode.sv
module ldet_mode_decode
    import ldet_pkg::*;
(
    input  logic [3:0] cmd,
    output mode_cls_t  cls,
    output logic       is_cdp
);

    always_comb begin
        cls    = cmd_class(cmd);
        is_cdp = (cmd == CMD_CDP);
    end

endmodule

// File: rtl/ldet_win_timer.sv
module ldet_win_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (tick && cnt != LIM_V)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LIM_V);

endmodule

// File: rtl/ldet_status_gen.sv
module ldet_status_gen
    import ldet_pkg::*;
#(
    parameter int ASSERT_TICKS  = 200,
    parameter int RELEASE_TICKS = 3000,
    parameter int IDLE_TICKS    = 15001,
    parameter int DISCH_TICKS   = 2001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cmd,
    input  logic       tick,
    input  logic       load_hi,
    input  logic       load_lo,
    input  logic       pw_idle,
    input  logic       ilim_hit,
    input  logic       prim_det,
    output logic       status_n,
    output logic       lim_low_pwr,
    output logic       dischg_req
);

    localparam int WIN_LIM [NUM_WIN] = '{ASSERT_TICKS, RELEASE_TICKS, IDLE_TICKS, DISCH_TICKS};

    mode_cls_t   cls;
    logic        is_cdp;
    ldet_state_t state, nxt;
    logic [NUM_WIN-1:0] win_run;
    logic [NUM_WIN-1:0] win_done;

    ldet_mode_decode i_dec (
        .cmd    (cmd),
        .cls    (cls),
        .is_cdp (is_cdp)
    );

    always_comb begin
        win_run          = '0;
        win_run[WIN_ARM] = (state == ST_WATCH)    && (cls == MC_LOAD) && load_hi;
        win_run[WIN_REL] = (state == ST_LOADED)   && (cls == MC_LOAD) && load_lo;
        win_run[WIN_IDL] = (state == ST_PW_HIGH)  && (cls == MC_PW)   && pw_idle;
        win_run[WIN_DIS] = (state == ST_PW_DISCH) && (cls == MC_PW);
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        ldet_win_timer #(.LIMIT(WIN_LIM[g])) i_win (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (win_run[g]),
            .tick  (tick),
            .done  (win_done[g])
        );
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                nxt = entry_state(cls);
            end
            ST_WATCH: begin
                if (cls != MC_LOAD)
                    nxt = entry_state(cls);
                else if ((is_cdp && prim_det) || win_done[WIN_ARM])
                    nxt = ST_LOADED;
            end
            ST_LOADED: begin
                if (cls != MC_LOAD)
                    nxt = entry_state(cls);
                else if (win_done[WIN_REL] && !(is_cdp && prim_det))
                    nxt = ST_WATCH;
            end
            ST_PW_HIGH: begin
                if (cls != MC_PW)
                    nxt = entry_state(cls);
                else if (win_done[WIN_IDL])
                    nxt = ST_PW_LOW;
            end
            ST_PW_LOW: begin
                if (cls != MC_PW)
                    nxt = entry_state(cls);
                else if (ilim_hit)
                    nxt = ST_PW_DISCH;
            end
            ST_PW_DISCH: begin
                if (cls != MC_PW)
                    nxt = entry_state(cls);
                else if (win_done[WIN_DIS])
                    nxt = ST_PW_HIGH;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        status_n    = 1'b1;
        lim_low_pwr = 1'b0;
        dischg_req  = 1'b0;
        unique case (state)
            ST_IDLE, ST_WATCH: begin
                status_n = 1'b1;
            end
            ST_LOADED, ST_PW_HIGH: begin
                status_n = 1'b0;
            end
            ST_PW_LOW: begin
                lim_low_pwr = 1'b1;
            end
            ST_PW_DISCH: begin
                status_n   = 1'b0;
                dischg_req = 1'b1;
            end
            default: status_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/ldet_status_gen_chk.sv
module ldet_status_gen_chk
    import ldet_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd,
    input logic       tick,
    input logic       load_hi,
    input logic       load_lo,
    input logic       pw_idle,
    input logic       ilim_hit,
    input logic       prim_det,
    input logic       status_n,
    input logic       lim_low_pwr,
    input logic       dischg_req
);

    // R2: an inactive command leaves every output quiet one clock later
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_class(cmd) == MC_OFF) |=> (status_n && !lim_low_pwr && !dischg_req));

    // R5: primary detection under the CDP command asserts status at once
    a_r5_prim_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CDP && prim_det) |=> !status_n);

    // R7: the low-power limit is only entered after an idle load
    a_r7_doze_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lim_low_pwr) |-> $past(pw_idle));

    // R8: a discharge request starts only on a current-limit hit
    a_r8_wake_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dischg_req) |-> $past(ilim_hit));

    // R9: the SDP/CDP pair of commands never yields a discharge
    a_r9_no_dis_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b1110 || cmd == CMD_CDP) |=> !dischg_req);

    // R10: discharge is requested only under the power-wake command
    a_r10_dis_pw_only: assert property (@(posedge clk) disable iff (!rst_n)
        dischg_req |-> ($past(cmd) == CMD_PW));

    // R1: outputs are quiet while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (status_n && !lim_low_pwr && !dischg_req));

endmodule

bind ldet_status_gen ldet_status_gen_chk i_chk (.*);

// File: tb/test_ldet_status_gen.sv
`timescale 1ns/1ps
module test_ldet_status_gen;

    localparam int A_T = 20;
    localparam int R_T = 30;
    localparam int I_T = 40;
    localparam int D_T = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = 4'b0000;
    logic       tick = 1'b0;
    logic       load_hi = 1'b0;
    logic       load_lo = 1'b0;
    logic       pw_idle = 1'b0;
    logic       ilim_hit = 1'b0;
    logic       prim_det = 1'b0;
    logic       status_n, lim_low_pwr, dischg_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldet_status_gen #(
        .ASSERT_TICKS(A_T), .RELEASE_TICKS(R_T),
        .IDLE_TICKS(I_T), .DISCH_TICKS(D_T)
    ) i_ldet_status_gen (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick(tick),
        .load_hi(load_hi), .load_lo(load_lo), .pw_idle(pw_idle),
        .ilim_hit(ilim_hit), .prim_det(prim_det),
        .status_n(status_n), .lim_low_pwr(lim_low_pwr), .dischg_req(dischg_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic quiet_start();
        @(negedge clk);
        cmd = 4'b0010; load_hi = 0; load_lo = 0; pw_idle = 0; ilim_hit = 0; prim_det = 0;
        cyc(2);
    endtask

    task automatic t_reset();
        cyc(1);
        chk("R1", "status_n", status_n, 1'b1);
        chk("R1", "lim_low_pwr", lim_low_pwr, 1'b0);
        chk("R1", "dischg_req", dischg_req, 1'b0);
    endtask

    task automatic t_inactive();
        quiet_start();
        cmd = 4'b1110; load_hi = 1; load_lo = 1; pw_idle = 1; ilim_hit = 1; prim_det = 1;
        ticks(I_T + 5);
        chk("R2", "status_n under 1110", status_n, 1'b1);
        chk("R2", "dischg_req under 1110", dischg_req, 1'b0);
        chk("R2", "lim_low_pwr under 1110", lim_low_pwr, 1'b0);
        cmd = 4'b0001;
        cyc(2);
        chk("R2", "status_n under 0001", status_n, 1'b1);
    endtask

    task automatic t_assert_release();
        quiet_start();
        cmd = 4'b0111; cyc(2);
        load_hi = 1;
        ticks(A_T - 1);
        chk("R3", "status_n one tick early", status_n, 1'b1);
        ticks(1);
        chk("R3", "status_n after window", status_n, 1'b0);
        load_hi = 0; load_lo = 1;
        ticks(R_T - 1);
        chk("R6", "status_n one tick early", status_n, 1'b0);
        ticks(1);
        chk("R6", "status_n after release", status_n, 1'b1);
    endtask

    task automatic t_restart();
        quiet_start();
        cmd = 4'b1111; cyc(2);
        load_hi = 1; ticks(A_T - 1);
        load_hi = 0; ticks(1);
        load_hi = 1; ticks(A_T - 1);
        chk("R4", "status_n after broken window", status_n, 1'b1);
        ticks(1);
        chk("R4", "status_n after full window", status_n, 1'b0);
        load_hi = 0; load_lo = 1; ticks(R_T - 1);
        load_lo = 0; ticks(1);
        load_lo = 1; ticks(R_T - 1);
        chk("R4", "status_n after broken release", status_n, 1'b0);
        ticks(1);
        chk("R6", "status_n after full release", status_n, 1'b1);
    endtask

    task automatic t_prim();
        quiet_start();
        cmd = 4'b0111; cyc(2);
        prim_det = 1; cyc(4);
        chk("R5", "prim_det ignored under 0111", status_n, 1'b1);
        prim_det = 0;
        cmd = 4'b1111; cyc(2);
        prim_det = 1; cyc(1);
        chk("R5", "status_n next clock after prim_det", status_n, 1'b0);
        prim_det = 0; load_lo = 1;
        ticks(R_T);
        chk("R6", "status_n released after prim_det", status_n, 1'b1);
    endtask

    task automatic t_pair();
        int seen = 0;
        quiet_start();
        cmd = 4'b1111; cyc(2);
        prim_det = 1; cyc(1); prim_det = 0;
        for (int i = 0; i < 10; i++) begin
            cmd = (i % 2 == 0) ? 4'b1110 : 4'b1111;
            cyc(1);
            if (dischg_req) seen++;
        end
        chk("R9", "no discharge over 1110/1111 toggles", logic'(seen != 0), 1'b0);
        cmd = 4'b1110; cyc(2);
        chk("R9", "status_n under 1110", status_n, 1'b1);
    endtask

    task automatic t_power_wake();
        quiet_start();
        cmd = 4'b0011; cyc(2);
        chk("R7", "status_n on entry", status_n, 1'b0);
        chk("R7", "lim_low_pwr on entry", lim_low_pwr, 1'b0);
        pw_idle = 1;
        ticks(I_T - 1);
        chk("R7", "lim_low_pwr one tick early", lim_low_pwr, 1'b0);
        ticks(1);
        chk("R7", "lim_low_pwr after idle window", lim_low_pwr, 1'b1);
        chk("R7", "status_n after idle window", status_n, 1'b1);
        ilim_hit = 1; cyc(1); ilim_hit = 0;
        chk("R8", "dischg_req after hit", dischg_req, 1'b1);
        chk("R8", "status_n after hit", status_n, 1'b0);
        ticks(D_T - 1);
        chk("R8", "dischg_req one tick early", dischg_req, 1'b1);
        ticks(1);
        chk("R8", "dischg_req after window", dischg_req, 1'b0);
        chk("R8", "lim_low_pwr restored high", lim_low_pwr, 1'b0);
        chk("R8", "status_n low after restore", status_n, 1'b0);
    endtask

    task automatic t_abort();
        quiet_start();
        cmd = 4'b0011; cyc(2);
        pw_idle = 1; ticks(I_T);
        ilim_hit = 1; cyc(1); ilim_hit = 0;
        chk("R10", "discharge started", dischg_req, 1'b1);
        cmd = 4'b0010; cyc(1);
        chk("R10", "discharge withdrawn on leaving 0011", dischg_req, 1'b0);
    endtask

    initial begin
        cyc(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_inactive();
        t_assert_release();
        t_restart();
        t_prim();
        t_pair();
        t_power_wake();
        t_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule